// File: doc/BRIEF.md
# Keyed-Service Software Watchdog

This block keeps a system from hanging when software stops making progress. A down-counter runs from a programmed reload count. Software must write a two-word key, 16'h556C followed by 16'hAA39, to the service input before the counter reaches zero. A valid key pair reloads the counter. If the counter reaches zero first, the block raises a one-cycle expiry request. A select bit routes that request either to the reset sequencer or to the non-maskable interrupt line.

The block leaves hard reset already enabled, so software that never services it still causes a reset. Software may write the configuration once after each reset. That write sets the enable, the request routing, an optional divide-by-`PRE_DIV` prescaler and the 16-bit reload count. The hardware then locks the configuration against any further writes.

Both write inputs are single-cycle strobes. The block accepts every strobe and never stalls the writer. The two request outputs are plain level pins, each high for exactly one cycle per expiry.

Top module: `keyed_watchdog`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both requests are low. Reset leaves the block enabled, routed to reset, without prescale and with count `RST_COUNT`. With no service, the first request appears `RST_COUNT`+1 cycles after reset is released.
- R2: The counter reloads only when 16'hAA39 is written directly after 16'h556C. The next expiry then follows the reload by the programmed period.
- R3: While waiting for the first key, a value other than 16'h556C does nothing. 16'h556C arms the sequence but does not reload the counter.
- R4: While waiting for the second key, 16'hAA39 reloads the counter. Any other value, including 16'h556C, disarms the sequence without a reload.
- R5: Any number of idle cycles may pass between the two key writes. The reload still happens if the second key arrives before expiry.
- R6: From a reload, expiry comes after N+1 cycles without prescale, or N*`PRE_DIV`+1 cycles with prescale, where N is the reload count (N >= 1).
- R7: When the select bit is 0, expiry pulses `rst_req`. When the select bit is 1, expiry pulses `nmi_req`. The two requests are never high together.
- R8: The first configuration write after reset takes all fields and restarts the count. Every later configuration write, until the next reset, has no effect.
- R9: A configuration write with the enable bit at 0 freezes the counter. No request is raised after that, even if software services the block.
- R10: Each expiry request lasts one cycle. The expiry reloads the counter and disarms the key sequence, so a first key written before the expiry does not count after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 16 | Service write data (key value) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable bit of the configuration write |
| cfg_nmi_sel | input | 1 | Routing bit: 1 selects the interrupt request, 0 the reset request |
| cfg_prescale | input | 1 | 1 inserts the divide-by-`PRE_DIV` prescaler |
| cfg_count | input | 16 | Reload count |
| rst_req | output | 1 | One-cycle reset request on expiry |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request on expiry |

## Verification
The assertions assume that both write strobes are known after reset and that any reload count in use is at least 1. With a count of zero, the counter would re-expire on a two-cycle cadence that the period properties do not describe. The stimulus only ever programs counts of 1 or more. It spaces key writes so that the second key lands before the counter reaches zero, except in the one case that deliberately lets expiry fall between the two keys. Configuration writes are always placed right after reset or well away from an expiry cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 16;

  typedef enum logic {
    KEY_WAIT_A = 1'b0,
    KEY_WAIT_B = 1'b1
  } key_state_e;

  typedef struct packed {
    logic             en;
    logic             nmi_sel;
    logic             pre;
    logic [CNT_W-1:0] count;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
#(
  parameter wdt_cfg_t RST_CFG = '{en: 1'b1, nmi_sel: 1'b0, pre: 1'b0, count: '1}
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  wdt_cfg_t wr_cfg,
  output wdt_cfg_t cfg,
  output logic     locked,
  output logic     accept
);
  // a write lands only while the register is still open
  assign accept = wr & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= RST_CFG;
      locked <= 1'b0;
    end else if (accept) begin
      cfg    <= wr_cfg;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_pkg::*;
#(
  parameter int             KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_A = 16'h556C,
  parameter logic [KEY_W-1:0] KEY_B = 16'hAA39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [KEY_W-1:0] data,
  input  logic             expire,
  output logic             reload,
  output key_state_e       state
);
  key_state_e state_nx;

  assign reload = wr && (state == KEY_WAIT_B) && (data == KEY_B);

  always_comb begin
    state_nx = state;
    if (reload || expire) begin
      state_nx = KEY_WAIT_A;
    end else if (wr) begin
      unique case (state)
        KEY_WAIT_A: state_nx = (data == KEY_A) ? KEY_WAIT_B : KEY_WAIT_A;
        KEY_WAIT_B: state_nx = KEY_WAIT_A;
        default:    state_nx = KEY_WAIT_A;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= KEY_WAIT_A;
    else        state <= state_nx;
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ clr;
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      assign tick = run && (phase == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase <= '0;
        else if (clr)     phase <= '0;
        else if (run)     phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int             W       = 16,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         fire_now,
  output logic         pulse
);
  // expiry yields to any load in the same cycle and never repeats back to back
  assign fire_now = en && (cnt == '0) && !load && !pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= RST_VAL;
      pulse <= 1'b0;
    end else begin
      pulse <= fire_now;
      if (load || fire_now)             cnt <= load_val;
      else if (en && tick && cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int               KEY_W     = 16,
  parameter logic [KEY_W-1:0] KEY_A     = 16'h556C,
  parameter logic [KEY_W-1:0] KEY_B     = 16'hAA39,
  parameter int               PRE_DIV   = 2048,
  parameter bit               RST_EN    = 1'b1,
  parameter bit               RST_NMI   = 1'b0,
  parameter bit               RST_PRE   = 1'b0,
  parameter logic [CNT_W-1:0] RST_COUNT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_wr,
  input  logic [KEY_W-1:0] svc_data,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic             cfg_nmi_sel,
  input  logic             cfg_prescale,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             rst_req,
  output logic             nmi_req
);
  localparam wdt_cfg_t RST_CFG = '{en: RST_EN, nmi_sel: RST_NMI, pre: RST_PRE, count: RST_COUNT};

  wdt_cfg_t         cfg_in, cfg_q;
  logic             cfg_locked, cfg_accept;
  logic             svc_reload, fire_now, pulse_q;
  logic             pre_tick, cnt_tick, cnt_load;
  logic [CNT_W-1:0] cnt_val, load_val;
  key_state_e       key_st;

  assign cfg_in = '{en: cfg_en, nmi_sel: cfg_nmi_sel, pre: cfg_prescale, count: cfg_count};

  wdt_cfg_reg #(.RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_cfg(cfg_in),
    .cfg(cfg_q), .locked(cfg_locked), .accept(cfg_accept)
  );

  wdt_key_fsm #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_n), .wr(svc_wr), .data(svc_data),
    .expire(fire_now), .reload(svc_reload), .state(key_st)
  );

  assign cnt_load = svc_reload | cfg_accept;
  assign load_val = cfg_accept ? cfg_count : cfg_q.count;

  wdt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.en & cfg_q.pre),
    .clr(cnt_load | fire_now), .tick(pre_tick)
  );

  assign cnt_tick = cfg_q.pre ? pre_tick : 1'b1;

  wdt_down_counter #(.W(CNT_W), .RST_VAL(RST_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .tick(cnt_tick),
    .load(cnt_load), .load_val(load_val),
    .cnt(cnt_val), .fire_now(fire_now), .pulse(pulse_q)
  );

  assign rst_req = pulse_q & ~cfg_q.nmi_sel;
  assign nmi_req = pulse_q &  cfg_q.nmi_sel;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int               KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_B = 16'hAA39
) (
  input logic             clk,
  input logic             rst_n,
  input logic             svc_wr,
  input logic [KEY_W-1:0] svc_data,
  input logic             rst_req,
  input logic             nmi_req,
  input key_state_e       key_st,
  input logic [CNT_W-1:0] cnt,
  input wdt_cfg_t         cfg,
  input logic             locked
);
  // R7
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && nmi_req));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || nmi_req) |=> !(rst_req || nmi_req));

  // R10
  expiry_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || nmi_req) |-> (key_st == KEY_WAIT_A && cnt == cfg.count));

  // R2
  key_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_st == KEY_WAIT_B && svc_wr && svc_data == KEY_B) |=> (cnt == cfg.count));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !(rst_req || nmi_req));
endmodule

bind keyed_watchdog wdt_checker #(.KEY_W(KEY_W), .KEY_B(KEY_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_data(svc_data),
  .rst_req(rst_req), .nmi_req(nmi_req), .key_st(key_st),
  .cnt(cnt_val), .cfg(cfg_q), .locked(cfg_locked)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  localparam int N0  = 20;
  localparam int DIV = 4;
  localparam logic [15:0] KA = 16'h556C;
  localparam logic [15:0] KB = 16'hAA39;

  logic clk = 1'b0, rst_n = 1'b0;
  logic svc_wr = 1'b0, cfg_wr = 1'b0;
  logic [15:0] svc_data = '0, cfg_count = '0;
  logic cfg_en = 1'b0, cfg_nmi_sel = 1'b0, cfg_prescale = 1'b0;
  logic rst_req, nmi_req;

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  keyed_watchdog #(.PRE_DIV(DIV), .RST_COUNT(16'(N0))) u0 (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_data(svc_data),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_nmi_sel(cfg_nmi_sel),
    .cfg_prescale(cfg_prescale), .cfg_count(cfg_count),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // requirement-level model: which edge fires, from the last load edge
  int m_load, m_n;
  bit m_st, m_en, m_sel, m_pre, m_lock, m_fire, m_acc, m_rel;
  always @(posedge clk) begin
    cyc++;
    m_fire = 1'b0;
    if (!rst_n) begin
      m_st = 0; m_load = cyc; m_en = 1; m_sel = 0; m_pre = 0; m_n = N0; m_lock = 0;
    end else begin
      m_acc = cfg_wr && !m_lock;
      m_rel = svc_wr && m_st && (svc_data == KB);
      if (!m_acc && !m_rel && m_en && cyc == m_load + m_n * (m_pre ? DIV : 1) + 1) m_fire = 1'b1;
      if (m_acc) begin
        m_lock = 1; m_en = cfg_en; m_sel = cfg_nmi_sel; m_pre = cfg_prescale; m_n = int'(cfg_count);
      end
      if (m_rel || m_fire)  m_st = 0;
      else if (svc_wr)      m_st = m_st ? 1'b0 : (svc_data == KA);
      if (m_acc || m_rel || m_fire) m_load = cyc;
    end
  end

  // every cycle: request pins against the model (R7, R10 and the current phase)
  int pulses = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req || nmi_req) pulses++;
      check(rst_req == (m_fire && !m_sel), {phase, " rst_req"}, int'(rst_req), int'(m_fire && !m_sel));
      check(nmi_req == (m_fire && m_sel),  {phase, " nmi_req"}, int'(nmi_req), int'(m_fire && m_sel));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic svc(input logic [15:0] v, output int e);
    svc_data = v; svc_wr = 1'b1; e = cyc + 1;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic cfg(input bit en, input bit sel, input bit pre, input int n, output int e);
    cfg_en = en; cfg_nmi_sel = sel; cfg_prescale = pre; cfg_count = 16'(n);
    cfg_wr = 1'b1; e = cyc + 1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_pulse(input int maxc, output int at);
    at = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (rst_req || nmi_req) begin at = cyc; break; end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    check(!rst_req && !nmi_req, "R1 outputs in reset", int'(rst_req | nmi_req), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int p, q, e, e1, e2, rel, c0;
    logic [15:0] vals [7] = '{KA, KB, 16'h0000, 16'hFFFF, 16'h556D, 16'hAA38, 16'h6C55};
    logic [15:0] tri_v [4][3] = '{'{KA, KA, KB}, '{16'h1234, KA, KB}, '{KA, 16'h1234, KB}, '{KA, KB, KB}};
    int tri_rel [4] = '{-1, 2, -1, 1};

    // R1: reset values and unserviced first expiry
    idle(2);
    do_reset();
    c0 = cyc;
    @(negedge clk);
    check(!rst_req && !nmi_req, "R1 first cycle after reset", int'(rst_req | nmi_req), 0);
    wait_pulse(200, p);
    check(p == c0 + N0 + 1, "R1 first expiry cycle", p, c0 + N0 + 1);
    check(rst_req && !nmi_req, "R1 routed to reset", int'(nmi_req), 0);

    // R2 R3 R4: sweep of all key pairs
    phase = "R2/R3/R4 pair sweep";
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        int gap;
        bit ok;
        gap = (i * 3 + j) % 10;
        wait_pulse(200, p);
        idle(4);
        svc(vals[i], e1);
        idle(gap);
        svc(vals[j], e2);
        ok = (vals[i] == KA) && (vals[j] == KB);
        wait_pulse(200, q);
        check(q == (ok ? e2 + N0 + 1 : p + N0 + 1), "R2 pair reload timing", q, ok ? e2 + N0 + 1 : p + N0 + 1);
      end
    end

    // R3 R4: three-write orderings
    phase = "R3/R4 triples";
    for (int t = 0; t < 4; t++) begin
      int ev [3];
      wait_pulse(200, p);
      for (int k = 0; k < 3; k++) begin
        svc(tri_v[t][k], ev[k]);
        idle(1);
      end
      rel = (tri_rel[t] < 0) ? p : ev[tri_rel[t]];
      wait_pulse(200, q);
      check(q == rel + N0 + 1, (t == 1) ? "R3 junk then keys reload" : "R4 broken sequence", q, rel + N0 + 1);
    end

    // R5: long pause between the keys
    phase = "R5 long gap";
    wait_pulse(200, p);
    svc(KA, e1);
    idle(N0 - 4);
    svc(KB, e2);
    wait_pulse(200, q);
    check(q == e2 + N0 + 1, "R5 late second key reloads", q, e2 + N0 + 1);

    // R10: expiry between the keys disarms the sequence
    phase = "R10 expiry disarms";
    wait_pulse(200, p);
    svc(KA, e1);
    wait_pulse(200, q);
    check(q == p + N0 + 1, "R10 expiry after first key", q, p + N0 + 1);
    svc(KB, e2);
    wait_pulse(200, q);
    check(q == p + 2 * (N0 + 1), "R10 second key after expiry ignored", q, p + 2 * (N0 + 1));

    // R6 R7 R8: prescaled, interrupt routing, write-once
    phase = "R6/R7/R8 prescale nmi";
    do_reset();
    cfg(1, 1, 1, 5, e);
    wait_pulse(400, q);
    check(q == e + 5 * DIV + 1, "R6 prescaled period", q, e + 5 * DIV + 1);
    check(nmi_req && !rst_req, "R7 routed to interrupt", int'(rst_req), 0);
    cfg(0, 0, 0, 3, e1);
    wait_pulse(400, p);
    check(p == q + 5 * DIV + 1, "R8 second config write ignored", p, q + 5 * DIV + 1);
    check(nmi_req && !rst_req, "R8 routing unchanged", int'(nmi_req), 1);

    // R6: smallest count
    phase = "R6 count one";
    do_reset();
    cfg(1, 0, 0, 1, e);
    wait_pulse(50, p);
    check(p == e + 2, "R6 count 1 period", p, e + 2);
    wait_pulse(50, q);
    check(q == p + 2, "R6 count 1 repeat", q, p + 2);

    // R9: disabled through the single write, then a locked re-enable attempt
    phase = "R9 disabled";
    do_reset();
    cfg(0, 0, 0, 3, e);
    c0 = pulses;
    svc(KA, e1);
    svc(KB, e2);
    idle(300);
    cfg(1, 0, 0, 3, e);
    idle(100);
    check(pulses == c0, "R9 no request while disabled", pulses - c0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule